// File: doc/BRIEF.md
# Outstanding Miss Tracker with Register Scoreboard

This block lets a non-blocking data cache keep an in-order pipeline moving past load misses. It holds a small table of memory lines currently being fetched. For every word of each line, the table records which destination register, if any, is waiting on that word. A load that misses either opens a new entry, which sends one line request to memory, or joins an entry that already covers the same line. Joining an entry sends no new request. The load's destination register is then marked empty, and the load leaves the pipeline.

The block keeps a full/empty bit for each architectural register. Decode asks, through the lookup ports, whether a source register is still empty, and holds the instruction while it is. When memory returns a line, the block emits one write strobe for each word slot that has a waiting register. The register file takes word `i` of the returned data for write port `i`. The block marks those registers full and frees the entry, all in the same cycle.

The block only tracks registers and does not store data. The register file takes the returned words straight from the memory response bus.

Top module: `miss_tracker`

## Requirements
- R1: After reset every register reads full on the lookup ports, `mem_req_valid` is low, all `wb_valid` bits are low, and `miss_stall` is low while `miss_valid` is low.
- R2: A miss to a line with no entry, with a free entry available, raises `mem_req_valid` with `mem_req_line` equal to the miss line. The miss is accepted (`miss_stall` low) only in a cycle where `mem_req_ready` is high. Otherwise it is stalled.
- R3: Once a miss is accepted, its destination register reads empty on the lookup ports from the next cycle. Other registers are unaffected.
- R4: A miss to a line that already has an entry, whose word slot is free, is accepted in that cycle without raising `mem_req_valid`.
- R5: A miss to a tracked line whose word slot already holds a waiting register is stalled. Its destination register stays full.
- R6: When all ENTRIES entries are busy, a miss to a new line is stalled and `mem_req_valid` stays low.
- R7: A miss whose destination register is already empty is stalled and raises no request.
- R8: A response whose `rsp_line` matches an entry raises `wb_valid[i]` in the same cycle for each word `i` that has a waiting register, with `wb_reg` slice `i` naming that register. Those registers read full from the next cycle, and the entry is free for a new line.
- R9: A response for a line that no entry tracks produces no write strobes and changes no register state.
- R10: A miss for the line carried by a response in the same cycle is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load missed in the cache this cycle |
| miss_line | input | LINE_AW | Line address of the missing load |
| miss_word | input | log2(WORDS) | Word within the line that the load wants |
| miss_rd | input | log2(NREGS) | Destination register of the load |
| miss_stall | output | 1 | The miss cannot be taken this cycle; hold the load |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_line | output | LINE_AW | Line address requested |
| rsp_valid | input | 1 | A refilled line returns this cycle |
| rsp_line | input | LINE_AW | Line address of the refill |
| wb_valid | output | WORDS | Per-word register write strobe |
| wb_reg | output | WORDS*log2(NREGS) | Register to write for each word |
| look_reg | input | NLOOK*log2(NREGS) | Source registers queried by decode |
| look_empty | output | NLOOK | Queried register is still waiting for data |

## Verification
The hardest case to reach is a refill that lands in the same cycle as a new miss to that very line, while the table is also full. That cycle combines the same-line stall, the per-word write strobes and the freeing of an entry. The bench first fills all four entries, one of them carrying two merged registers. It shows that a fifth line is refused. It then presents the refill and the conflicting miss together, and confirms afterwards that the freed entry takes the previously refused line.

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int NREGS   = 32,
  parameter int LINE_AW = 26,
  parameter int NLOOK   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 miss_valid,
  input  logic [LINE_AW-1:0]                   miss_line,
  input  logic [$clog2(WORDS)-1:0]             miss_word,
  input  logic [$clog2(NREGS)-1:0]             miss_rd,
  output logic                                 miss_stall,
  output logic                                 mem_req_valid,
  input  logic                                 mem_req_ready,
  output logic [LINE_AW-1:0]                   mem_req_line,
  input  logic                                 rsp_valid,
  input  logic [LINE_AW-1:0]                   rsp_line,
  output logic [WORDS-1:0]                     wb_valid,
  output logic [WORDS*$clog2(NREGS)-1:0]       wb_reg,
  input  logic [NLOOK*$clog2(NREGS)-1:0]       look_reg,
  output logic [NLOOK-1:0]                     look_empty
);
  localparam int WI = $clog2(WORDS);
  localparam int RW = $clog2(NREGS);
  localparam int EI = $clog2(ENTRIES);

  logic [ENTRIES-1:0] ent_valid;
  logic [LINE_AW-1:0] ent_line [ENTRIES];
  logic [WORDS-1:0]   slot_v   [ENTRIES];
  logic [RW-1:0]      slot_r   [ENTRIES][WORDS];
  logic [NREGS-1:0]   reg_full, full_nxt;

  logic [ENTRIES-1:0] hit_vec, rsp_vec;
  logic [EI-1:0]      hit_idx, rsp_idx, free_idx;
  logic               any_hit, any_rsp, have_free;

  always_comb begin
    hit_idx = '0; rsp_idx = '0; free_idx = '0; have_free = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      hit_vec[e] = ent_valid[e] && (ent_line[e] == miss_line);
      rsp_vec[e] = rsp_valid && ent_valid[e] && (ent_line[e] == rsp_line);
      if (hit_vec[e]) hit_idx = EI'(e);
      if (rsp_vec[e]) rsp_idx = EI'(e);
    end
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!ent_valid[e]) begin
        free_idx  = EI'(e);
        have_free = 1'b1;
      end
  end

  assign any_hit = |hit_vec;
  assign any_rsp = |rsp_vec;

  logic slot_busy, rd_pending, rsp_clash, blocked, miss_fire;
  assign slot_busy  = any_hit && slot_v[hit_idx][miss_word];
  assign rd_pending = !reg_full[miss_rd];
  assign rsp_clash  = rsp_valid && (rsp_line == miss_line);
  assign blocked    = rd_pending || rsp_clash || (any_hit ? slot_busy : !have_free);

  assign mem_req_valid = miss_valid && !any_hit && have_free && !rd_pending && !rsp_clash;
  assign mem_req_line  = miss_line;
  assign miss_stall    = miss_valid && (blocked || (!any_hit && !mem_req_ready));
  assign miss_fire     = miss_valid && !miss_stall;

  genvar w, k;
  generate
    for (w = 0; w < WORDS; w++) begin : g_wb
      assign wb_valid[w]           = any_rsp && slot_v[rsp_idx][w];
      assign wb_reg[w*RW +: RW]    = slot_r[rsp_idx][w];
    end
    for (k = 0; k < NLOOK; k++) begin : g_look
      assign look_empty[k] = !reg_full[look_reg[k*RW +: RW]];
    end
  endgenerate

  always_comb begin
    full_nxt = reg_full;
    for (int i = 0; i < WORDS; i++)
      if (wb_valid[i]) full_nxt[wb_reg[i*RW +: RW]] = 1'b1;
    if (miss_fire) full_nxt[miss_rd] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      reg_full  <= '1;
      for (int e = 0; e < ENTRIES; e++) begin
        ent_line[e] <= '0;
        slot_v[e]   <= '0;
        for (int i = 0; i < WORDS; i++) slot_r[e][i] <= '0;
      end
    end else begin
      reg_full <= full_nxt;
      for (int e = 0; e < ENTRIES; e++)
        if (rsp_vec[e]) begin
          ent_valid[e] <= 1'b0;
          slot_v[e]    <= '0;
        end
      if (miss_fire) begin
        if (any_hit) begin
          slot_v[hit_idx][miss_word] <= 1'b1;
          slot_r[hit_idx][miss_word] <= miss_rd;
        end else begin
          ent_valid[free_idx]           <= 1'b1;
          ent_line[free_idx]            <= miss_line;
          slot_v[free_idx]              <= WORDS'(1) << miss_word;
          slot_r[free_idx][miss_word]   <= miss_rd;
        end
      end
    end
  end

  assert_new_line_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_fire && !any_hit) |-> (mem_req_valid && mem_req_ready));

  assert_dest_marked_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> !reg_full[$past(miss_rd)]);

  assert_unique_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_no_req_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(ent_valid) < ENTRIES));

  assert_quiet_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_fire && !any_rsp) |=> $stable(reg_full));

  generate
    for (w = 0; w < WORDS; w++) begin : g_chk
      assert_wb_target_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid[w] |-> !reg_full[wb_reg[w*RW +: RW]]);
    end
  endgenerate
endmodule

// File: tb/miss_tracker_bench.sv
module miss_tracker_bench;
  localparam int RW = 5;
  localparam int AW = 26;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, mem_req_ready = 0, rsp_valid = 0;
  logic [AW-1:0] miss_line = '0, rsp_line = '0;
  logic [1:0] miss_word = '0;
  logic [RW-1:0] miss_rd = '0;
  logic [2*RW-1:0] look_reg = '0;
  logic miss_stall, mem_req_valid;
  logic [AW-1:0] mem_req_line;
  logic [3:0] wb_valid;
  logic [4*RW-1:0] wb_reg;
  logic [1:0] look_empty;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  miss_tracker u_miss_tracker (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word), .miss_rd(miss_rd),
    .miss_stall(miss_stall),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line),
    .rsp_valid(rsp_valid), .rsp_line(rsp_line),
    .wb_valid(wb_valid), .wb_reg(wb_reg),
    .look_reg(look_reg), .look_empty(look_empty));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_empty(input string req, input int r, input logic exp);
    look_reg[RW-1:0] = RW'(r);
    #0.5;
    check(req, 64'(look_empty[0]), 64'(exp));
  endtask

  // drive a miss at negedge, check comb outputs, let it cross one edge
  task automatic miss(input string req, input logic [AW-1:0] line, input int word, input int rd,
                      input logic rdy, input logic exp_stall, input logic exp_req);
    @(negedge clk);
    miss_valid = 1; miss_line = line; miss_word = 2'(word); miss_rd = RW'(rd);
    mem_req_ready = rdy;
    #0.5;
    check({req, " stall"}, 64'(miss_stall), 64'(exp_stall));
    check({req, " req"}, 64'(mem_req_valid), 64'(exp_req));
    if (exp_req) check({req, " req line"}, 64'(mem_req_line), 64'(line));
    @(posedge clk); #0.5;
    miss_valid = 0; mem_req_ready = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 req idle", 64'(mem_req_valid), 64'd0);
    check("R1 no writes", 64'(wb_valid), 64'd0);
    check("R1 no stall", 64'(miss_stall), 64'd0);
    begin
      int bad = 0;
      for (int r = 0; r < 32; r++) begin
        look_reg[RW-1:0] = RW'(r); #0.1;
        if (look_empty[0]) bad++;
      end
      check("R1 all regs full", 64'(bad), 64'd0);
    end
  endtask

  task automatic t_primary;
    miss("R2 primary A", 26'h0A0, 1, 5, 1, 0, 1);
    reg_empty("R3 r5 empty", 5, 1);
    reg_empty("R3 r6 untouched", 6, 0);
    miss("R2 no ready B", 26'h0B0, 0, 7, 0, 1, 1);
    reg_empty("R2 r7 still full", 7, 0);
    miss("R2 ready B", 26'h0B0, 0, 7, 1, 0, 1);
    reg_empty("R3 r7 empty", 7, 1);
  endtask

  task automatic t_merge;
    miss("R4 merge A w2", 26'h0A0, 2, 8, 0, 0, 0);
    reg_empty("R4 r8 empty", 8, 1);
    miss("R5 slot taken", 26'h0A0, 1, 9, 1, 1, 0);
    reg_empty("R5 r9 full", 9, 0);
    miss("R7 rd pending", 26'h0C0, 0, 5, 1, 1, 0);
  endtask

  task automatic t_full;
    miss("R2 alloc C", 26'h0C0, 0, 10, 1, 0, 1);
    miss("R2 alloc D", 26'h0D0, 3, 11, 1, 0, 1);
    miss("R6 table full", 26'h0E0, 0, 12, 1, 1, 0);
    reg_empty("R6 r12 full", 12, 0);
  endtask

  task automatic t_stray;
    @(negedge clk);
    rsp_valid = 1; rsp_line = 26'h0F0;
    #0.5;
    check("R9 no strobes", 64'(wb_valid), 64'd0);
    @(posedge clk); #0.5;
    rsp_valid = 0;
    reg_empty("R9 r5 still empty", 5, 1);
  endtask

  task automatic t_refill;
    @(negedge clk);
    rsp_valid = 1; rsp_line = 26'h0A0;
    miss_valid = 1; miss_line = 26'h0A0; miss_word = 2'd3; miss_rd = 5'd13; mem_req_ready = 1;
    #0.5;
    check("R10 clash stall", 64'(miss_stall), 64'd1);
    check("R8 strobes", 64'(wb_valid), 64'b0110);
    check("R8 word1 reg", 64'(wb_reg[1*RW +: RW]), 64'd5);
    check("R8 word2 reg", 64'(wb_reg[2*RW +: RW]), 64'd8);
    @(posedge clk); #0.5;
    rsp_valid = 0; miss_valid = 0; mem_req_ready = 0;
    reg_empty("R8 r5 full", 5, 0);
    reg_empty("R8 r8 full", 8, 0);
    reg_empty("R10 r13 full", 13, 0);
    miss("R8 freed entry reused", 26'h0E0, 0, 12, 1, 0, 1);
    @(negedge clk);
    rsp_valid = 1; rsp_line = 26'h0B0;
    #0.5;
    check("R8 B strobe", 64'(wb_valid), 64'b0001);
    check("R8 B reg", 64'(wb_reg[0 +: RW]), 64'd7);
    @(posedge clk); #0.5;
    rsp_valid = 0;
    reg_empty("R8 r7 full", 7, 0);
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    t_reset;
    t_primary;
    t_merge;
    t_full;
    t_stray;
    t_refill;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule